// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

A memory-mapped bank of up to 32 general-purpose pins. Software reaches it through a simple register port: a register index, a write strobe, write data and combinational read data. Each pin can be driven as an output or left as an input. Output values and interrupt enables are never written as whole words. Instead, separate write-one-to-set and write-one-to-clear registers change only the bits written as one, so a driver can touch one pin without a read-modify-write sequence.

Every input passes through a two-flop synchronizer. The synchronized value feeds the input register and the trigger detector. The trigger mode of each pin is held in three independent configuration bits: edge or level, one edge or both edges, and active polarity. Edge events are latched into a pending register that software acknowledges by writing ones. Level-mode pins report the live active level. A single interrupt line to the parent controller is raised while any enabled pin is pending.

Register indices (on `bus_addr_i`): 0 input, 1 output set, 2 output clear, 3 direction, 4 enable set, 5 enable clear, 6 pending, 7 edge-mode select, 8 both-edge select, 9 polarity select, 10 to 15 unused.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, `pin_out_o`, `pin_oe_o`, the enable, direction and all three configuration registers read zero, `irq_o` is low and no edge is latched. With every pin low, each pin is in level mode with low polarity, so pending (index 6) reads all ones.
- R2: Index 0 reads the synchronized pins. A pin value present before clock edge k reads back after edge k+1, whatever the direction register holds.
- R3: A write to index 1 sets the output bits written as one. A write to index 2 clears them. Zero bits leave their pins unchanged. Both indices read back the current output value, which drives `pin_out_o`.
- R4: Index 3 is a read/write direction register. Bit value 1 makes the pin an output, and the register drives `pin_oe_o`.
- R5: Writing ones to index 4 enables those pins' interrupts, and writing ones to index 5 disables them. Zero bits leave the enables unchanged. Both indices read the enable mask.
- R6: A pin whose bit in index 7 is 1 is edge-triggered. When its bit in index 8 is 0, it latches on a rising edge if its index 9 bit is 1, or on a falling edge if that bit is 0. A pin change present before edge k shows in pending after edge k+2.
- R7: An edge-triggered pin whose index 8 bit is 1 latches on both rising and falling edges, whatever its polarity bit holds.
- R8: A level-triggered pin (index 7 bit 0) shows pending exactly while its synchronized value equals its polarity bit. Writing an acknowledge to it has no effect while the level persists.
- R9: Writing a 1 to a bit of index 6 clears that pin's latched edge at the next clock. Zero bits leave other pending bits untouched.
- R10: If an edge is detected on a pin in the same cycle its acknowledge is written, the pending bit stays set.
- R11: `irq_o` is high exactly while some pin is both pending and enabled.
- R12: Indices 10 to 15 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 4 | Register index |
| bus_we_i | input | 1 | Write strobe for the indexed register |
| bus_wdata_i | input | NUM_PINS | Write data, one bit per pin |
| bus_rdata_o | output | NUM_PINS | Combinational read data of the indexed register |
| pin_in_i | input | NUM_PINS | Raw pin levels (asynchronous) |
| pin_out_o | output | NUM_PINS | Output values |
| pin_oe_o | output | NUM_PINS | Output enables (1 drives the pin) |
| irq_o | output | 1 | Combined interrupt to the parent controller |

## Verification
Register writes take effect at the clock edge that samples the strobe, and read data is combinational, so register results are read at the next falling edge. A pin change applied before edge k reaches the input register after edge k+1, a level-mode pending bit follows at that same point, and an edge-mode pending bit appears one edge later, after k+2. The directed checks step exactly those edge counts and also sample one edge early, so that a wrong latency shows as a mismatch. The random phase compares every cycle against a cycle-stepped bench model that advances on the same clock edges as the design.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RIX_IN        = 4'd0,
    RIX_OUT_SET   = 4'd1,
    RIX_OUT_CLR   = 4'd2,
    RIX_DIR       = 4'd3,
    RIX_IEN_SET   = 4'd4,
    RIX_IEN_CLR   = 4'd5,
    RIX_PEND      = 4'd6,
    RIX_TRIG_EDGE = 4'd7,
    RIX_TRIG_BOTH = 4'd8,
    RIX_TRIG_POL  = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [W-1:0] stage_q [SYNC_STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[LAST];
    end
  end

  assign sync_o = stage_q[LAST];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] cfg_edge_i,
  input  logic [W-1:0] cfg_both_i,
  input  logic [W-1:0] cfg_pol_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] pend_o
);
  function automatic logic [W-1:0] edge_hits(
    input logic [W-1:0] cur, input logic [W-1:0] old,
    input logic [W-1:0] edge_en, input logic [W-1:0] both, input logic [W-1:0] pol);
    logic [W-1:0] rise, fall;
    rise = cur & ~old;
    fall = ~cur & old;
    return edge_en & ((rise & (pol | both)) | (fall & (~pol | both)));
  endfunction

  function automatic logic [W-1:0] level_active(
    input logic [W-1:0] cur, input logic [W-1:0] pol);
    return ~(cur ^ pol);
  endfunction

  logic [W-1:0] latch_q;

  assign hit_o = edge_hits(sync_i, prev_i, cfg_edge_i, cfg_both_i, cfg_pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= (latch_q & ~ack_i) | hit_o;
  end

  assign pend_o = (latch_q & cfg_edge_i) | (~cfg_edge_i & level_active(sync_i, cfg_pol_i));

  // R9: an acknowledged pin without a fresh edge is clear one cycle later
  assert_ack_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_q & $past(ack_i) & ~$past(hit_o)) == '0));

  // R10: a detected edge always leaves its latch set, acknowledge or not
  assert_edge_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(hit_o) & ~latch_q) == '0));
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      in_sync_i,
  input  logic [W-1:0]      pend_i,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      ien_o,
  output logic [W-1:0]      cfg_edge_o,
  output logic [W-1:0]      cfg_both_o,
  output logic [W-1:0]      cfg_pol_o,
  output logic [W-1:0]      ack_o
);
  logic [W-1:0] out_q, dir_q, ien_q, edge_q, both_q, pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        RIX_OUT_SET:   out_q  <= out_q | wdata_i;
        RIX_OUT_CLR:   out_q  <= out_q & ~wdata_i;
        RIX_DIR:       dir_q  <= wdata_i;
        RIX_IEN_SET:   ien_q  <= ien_q | wdata_i;
        RIX_IEN_CLR:   ien_q  <= ien_q & ~wdata_i;
        RIX_TRIG_EDGE: edge_q <= wdata_i;
        RIX_TRIG_BOTH: both_q <= wdata_i;
        RIX_TRIG_POL:  pol_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      RIX_IN:                   rdata_o = in_sync_i;
      RIX_OUT_SET, RIX_OUT_CLR: rdata_o = out_q;
      RIX_DIR:                  rdata_o = dir_q;
      RIX_IEN_SET, RIX_IEN_CLR: rdata_o = ien_q;
      RIX_PEND:                 rdata_o = pend_i;
      RIX_TRIG_EDGE:            rdata_o = edge_q;
      RIX_TRIG_BOTH:            rdata_o = both_q;
      RIX_TRIG_POL:             rdata_o = pol_q;
      default:                  rdata_o = '0;
    endcase
  end

  assign ack_o      = (we_i && addr_i == RIX_PEND) ? wdata_i : '0;
  assign out_o      = out_q;
  assign dir_o      = dir_q;
  assign ien_o      = ien_q;
  assign cfg_edge_o = edge_q;
  assign cfg_both_o = both_q;
  assign cfg_pol_o  = pol_q;

  // R3: set and clear touch only the bits written as one
  assert_out_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RIX_OUT_SET) |=> (out_o == ($past(out_o) | $past(wdata_i))));
  assert_out_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RIX_OUT_CLR) |=> (out_o == ($past(out_o) & ~$past(wdata_i))));
  // R4: direction takes the written word
  assert_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RIX_DIR) |=> (dir_o == $past(wdata_i)));
  // R5: enable set and clear are per bit
  assert_ien_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RIX_IEN_SET) |=> (ien_o == ($past(ien_o) | $past(wdata_i))));
  assert_ien_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RIX_IEN_CLR) |=> (ien_o == ($past(ien_o) & ~$past(wdata_i))));
  // R12: unused indices leave every register unchanged
  assert_unused_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > RIX_TRIG_POL) |=> ($stable(out_o) && $stable(dir_o) && $stable(ien_o)
      && $stable(cfg_edge_o) && $stable(cfg_both_o) && $stable(cfg_pol_o)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [REG_AW-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] in_sync, in_prev, pend, hit, ack, ien;
  logic [NUM_PINS-1:0] cfg_edge, cfg_both, cfg_pol;

  gpio_in_sync #(.W(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_in_i),
    .sync_o(in_sync), .prev_o(in_prev));

  gpio_trig_detect #(.W(NUM_PINS)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(in_sync), .prev_i(in_prev),
    .cfg_edge_i(cfg_edge), .cfg_both_i(cfg_both), .cfg_pol_i(cfg_pol),
    .ack_i(ack), .hit_o(hit), .pend_o(pend));

  gpio_reg_file #(.W(NUM_PINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(bus_addr_i), .we_i(bus_we_i),
    .wdata_i(bus_wdata_i), .in_sync_i(in_sync), .pend_i(pend),
    .rdata_o(bus_rdata_o), .out_o(pin_out_o), .dir_o(pin_oe_o), .ien_o(ien),
    .cfg_edge_o(cfg_edge), .cfg_both_o(cfg_both), .cfg_pol_o(cfg_pol), .ack_o(ack));

  assign irq_o = |(pend & ien);

  // R11: with every enable clear the parent line stays low
  assert_irq_masked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien == '0) |-> !irq_o);
endmodule

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   addr = '0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] pins = '0;
  logic [W-1:0] pout, poe;
  logic         irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_in_i(pins),
    .pin_out_o(pout), .pin_oe_o(poe), .irq_o(irq));

  // cycle-stepped reference model, written bit by bit
  logic [W-1:0] m_s1, m_s2, m_pv, m_out, m_dir, m_ien, m_edge, m_both, m_pol, m_lat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_pv <= '0; m_out <= '0; m_dir <= '0;
      m_ien <= '0; m_edge <= '0; m_both <= '0; m_pol <= '0; m_lat <= '0;
    end else begin
      for (int i = 0; i < W; i++) begin
        bit fired, acked;
        fired = m_edge[i] && (m_s2[i] != m_pv[i]) && (m_both[i] || (m_s2[i] == m_pol[i]));
        acked = we && (addr == 4'd6) && wdata[i];
        if (fired) m_lat[i] <= 1'b1;
        else if (acked) m_lat[i] <= 1'b0;
        if (we) begin
          case (addr)
            4'd1: if (wdata[i]) m_out[i] <= 1'b1;
            4'd2: if (wdata[i]) m_out[i] <= 1'b0;
            4'd3: m_dir[i] <= wdata[i];
            4'd4: if (wdata[i]) m_ien[i] <= 1'b1;
            4'd5: if (wdata[i]) m_ien[i] <= 1'b0;
            4'd7: m_edge[i] <= wdata[i];
            4'd8: m_both[i] <= wdata[i];
            4'd9: m_pol[i] <= wdata[i];
            default: ;
          endcase
        end
      end
      m_s1 <= pins;
      m_s2 <= m_s1;
      m_pv <= m_s2;
    end
  end

  function automatic logic [W-1:0] m_pend();
    logic [W-1:0] p;
    for (int i = 0; i < W; i++)
      p[i] = m_edge[i] ? m_lat[i] : (m_s2[i] == m_pol[i]);
    return p;
  endfunction

  function automatic logic [W-1:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_s2;
      4'd1, 4'd2: return m_out;
      4'd3: return m_dir;
      4'd4, 4'd5: return m_ien;
      4'd6: return m_pend();
      4'd7: return m_edge;
      4'd8: return m_both;
      4'd9: return m_pol;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6: return "R9";
      4'd7, 4'd9: return "R6";
      4'd8: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [W-1:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 pin_out", pout, '0);
    chk("R1 pin_oe", poe, '0);
    chk("R1 irq", {31'd0, irq}, '0);
    rd_chk("R1 out", 4'd1, '0);
    rd_chk("R1 dir", 4'd3, '0);
    rd_chk("R1 ien", 4'd4, '0);
    rd_chk("R1 edge cfg", 4'd7, '0);
    rd_chk("R1 both cfg", 4'd8, '0);
    rd_chk("R1 pol cfg", 4'd9, '0);
    rd_chk("R1 pending level-low", 4'd6, 32'hFFFF_FFFF);

    // R2 synchronizer latency, independent of direction
    pins = 32'hA5A5_0F0F;
    step(1);
    rd_chk("R2 one edge early", 4'd0, '0);
    step(1);
    rd_chk("R2 input", 4'd0, 32'hA5A5_0F0F);
    wr(4'd3, 32'hFFFF_FFFF);
    rd_chk("R2 input as outputs", 4'd0, 32'hA5A5_0F0F);

    // R3 output set/clear
    wr(4'd1, 32'h0000_00F0);
    chk("R3 set", pout, 32'h0000_00F0);
    wr(4'd1, 32'h0000_0F00);
    chk("R3 set keeps", pout, 32'h0000_0FF0);
    wr(4'd2, 32'h0000_0030);
    chk("R3 clear", pout, 32'h0000_0FC0);
    wr(4'd2, 32'h0);
    rd_chk("R3 zero clear no effect", 4'd2, 32'h0000_0FC0);

    // R4 direction
    wr(4'd3, 32'h1234_5678);
    chk("R4 oe", poe, 32'h1234_5678);
    rd_chk("R4 readback", 4'd3, 32'h1234_5678);

    // R5 enable set/clear
    wr(4'd4, 32'h11);
    wr(4'd4, 32'h100);
    rd_chk("R5 set", 4'd4, 32'h111);
    wr(4'd5, 32'h10);
    rd_chk("R5 clear", 4'd5, 32'h101);

    // R12 unused index
    wr(4'd11, 32'hFFFF_FFFF);
    rd_chk("R12 unused read", 4'd11, '0);
    rd_chk("R12 out untouched", 4'd1, 32'h0000_0FC0);
    rd_chk("R12 ien untouched", 4'd4, 32'h101);

    // R6/R7 edges: pin0 rising, pin1 falling, pin2 both
    pins = '0;
    step(3);
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd9, 32'h1);
    wr(4'd8, 32'h4);
    wr(4'd6, 32'hFFFF_FFFF);
    rd_chk("R9 all acked", 4'd6, '0);
    pins = 32'h7;
    step(2);
    rd_chk("R6 one edge early", 4'd6, '0);
    step(1);
    rd_chk("R6 rising latched", 4'd6, 32'h5);
    wr(4'd6, 32'h1);
    rd_chk("R9 ack pin0 only", 4'd6, 32'h4);
    pins = '0;
    step(3);
    rd_chk("R7 falling + both", 4'd6, 32'h6);

    // R11 irq
    chk("R11 irq masked", {31'd0, irq}, '0);
    wr(4'd4, 32'h2);
    chk("R11 irq raised", {31'd0, irq}, 32'h1);
    wr(4'd6, 32'h2);
    chk("R11 irq dropped", {31'd0, irq}, '0);

    // R10 edge against simultaneous ack
    pins = 32'h1;
    step(3);
    rd_chk("R6 pin0 rise", 4'd6, 32'h5);
    pins = '0;
    step(3);
    rd_chk("R6 pin0 fall ignored", 4'd6, 32'h5);
    pins = 32'h1;
    step(2);
    wr(4'd6, 32'h1);
    rd_chk("R10 edge beats ack", 4'd6, 32'h5);
    wr(4'd6, 32'h1);
    rd_chk("R9 later ack clears", 4'd6, 32'h4);

    // R8 level high on pin4
    wr(4'd6, 32'h4);
    wr(4'd7, ~32'h10);
    wr(4'd9, 32'h11);
    rd_chk("R8 level inactive", 4'd6, '0);
    pins = 32'h11;
    step(2);
    rd_chk("R8 level active", 4'd6, 32'h10);
    wr(4'd6, 32'h10);
    rd_chk("R8 ack no effect", 4'd6, 32'h10);
    wr(4'd4, 32'h10);
    chk("R11 level irq", {31'd0, irq}, 32'h1);
    pins = 32'h1;
    step(2);
    rd_chk("R8 level released", 4'd6, '0);
    chk("R11 level irq low", {31'd0, irq}, '0);

    // random phase against the model
    for (int c = 0; c < 3000; c++) begin
      logic [3:0] a;
      if (($urandom % 3) == 0) pins = pins ^ ($urandom & $urandom);
      a = 4'($urandom % 12);
      addr = a;
      we = ($urandom % 2) == 1;
      wdata = $urandom;
      #1;
      chk(tag_of(a), rdata, m_read(a));
      chk("R11 random irq", {31'd0, irq}, {31'd0, |(m_pend() & m_ien)});
      chk("R3 random pin_out", pout, m_out);
      chk("R4 random pin_oe", poe, m_dir);
      @(negedge clk);
    end
    we = 1'b0;
    finish_run();
  end
endmodule